// File: doc/BRIEF.md
# Grouped GPIO Interrupt Summary

This block sits between a large array of GPIO pins and one interrupt input of a parent interrupt controller. Each pin supplies two flags, an interrupt status and a wake status, and the pin counts as pending when either flag is set. The pins are folded into a summary vector of 46 bits, one bit for each group of four consecutive pins. Software reads the vector as two 32-bit words. The low word holds bits 0 to 31, and the high word holds bits 32 to 45 with its upper bits zero.

The parent line is a one-cycle pulse. A pulse is raised when the block is armed and any summary bit is set. The pulse disarms the block, and the line stays low whatever the pins do until software writes the end-of-service bit in the control register. That write re-arms the block. If a pin is still pending at that point, a new pulse follows in the next cycle, so no source is lost between servicing and re-arming.

Register access uses plain control pins: a write strobe, a 2-bit address, write data and combinational read data. A register access always completes in its own cycle and never back-pressures, so no valid/ready pair is needed. The pin flags are level status inputs, not a stream.

Top module: `gpio_irq_summary`

## Requirements
- R1: After reset the parent line is low, every read address returns 0 and the block is armed.
- R2: Summary bit n equals the OR over pins 4n, 4n+1, 4n+2 and 4n+3 of their pending state, as sampled on the previous clock edge.
- R3: A pin is pending when its interrupt status or its wake status is 1, and either flag alone suffices.
- R4: Address 0 reads summary bits 0 to 31 in data bits 0 to 31. Address 1 reads summary bits 32 to 45 in data bits 0 to 13, and data bits 14 to 31 read 0.
- R5: When the block is armed and the summary is nonzero at a clock edge, the parent line is high for exactly one cycle after that edge and the block disarms. The exception is an end-of-service write sampled at the same edge.
- R6: While the block is disarmed, the parent line stays low whatever the pin flags do.
- R7: A write to address 2 with data bit 0 set is an end-of-service. It re-arms the block at that edge. If the summary is then nonzero, the parent line is high in the next cycle; otherwise a pulse follows the next time a pin becomes pending.
- R8: Address 2 always reads 0, including its end-of-service bit 0. A write to it with bit 0 clear does not re-arm.
- R9: Writes to addresses 0, 1 and 3 change nothing, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int_sts | input | 184 | Per-pin interrupt status flags |
| pin_wake_sts | input | 184 | Per-pin wake status flags |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 low word, 1 high word, 2 control, 3 unused |
| reg_wdata | input | 32 | Register write data, bit 0 of address 2 is end-of-service |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| parent_irq | output | 1 | Pulsed interrupt to the parent controller |

## Verification
A wrong grouping or a dropped pending flag shows on the summary words one cycle after the pin changes. A stuck or wrongly cleared arm state shows on the parent line within two cycles: as a missing pulse after new pending input or after end-of-service, or as a second pulse while disarmed. A cycle-accurate reference of the arm state and the summary vector runs beside the design. Every cycle it is compared against the parent line and the read data, across single-pin walks, stuck pending sources, coincident end-of-service and pulse, and random traffic.

// File: rtl/gisum_pkg.sv
package gisum_pkg;
  typedef enum logic [1:0] {
    SEL_SUM_LO = 2'd0,
    SEL_SUM_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } gisum_sel_e;

  localparam int SERVICE_DONE_BIT = 0;
endpackage

// File: rtl/gisum_group_reduce.sv
module gisum_group_reduce #(
  parameter int GROUPS     = 46,
  parameter int GROUP_PINS = 4,
  localparam int NPINS     = GROUPS * GROUP_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  int_sts,
  input  logic [NPINS-1:0]  wake_sts,
  output logic [GROUPS-1:0] summary_q
);
  logic [NPINS-1:0]  pending;
  logic [GROUPS-1:0] summary_d;

  assign pending = int_sts | wake_sts;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign summary_d[g] = |pending[g*GROUP_PINS +: GROUP_PINS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary_q <= '0;
    else        summary_q <= summary_d;
  end
endmodule

// File: rtl/gisum_arm_ctrl.sv
module gisum_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pending,
  input  logic service_done,
  output logic armed,
  output logic irq_pulse
);
  logic fire;

  assign fire = armed & any_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (service_done) armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
    end
  end
endmodule

// File: rtl/gisum_regs.sv
module gisum_regs
  import gisum_pkg::*;
#(
  parameter int GROUPS = 46,
  parameter int WORD_W = 32,
  localparam int SUM_W = 2 * WORD_W
) (
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [GROUPS-1:0] summary,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              service_done
);
  logic [SUM_W-1:0] sum_pad;
  gisum_sel_e       sel;
  logic             unused_wdata_bits;

  if (GROUPS > SUM_W) begin : g_bad_cfg
    $error("summary does not fit two words");
  end

  assign sel = gisum_sel_e'(reg_addr);

  always_comb begin
    sum_pad = '0;
    sum_pad[GROUPS-1:0] = summary;
  end

  always_comb begin
    unique case (sel)
      SEL_SUM_LO: reg_rdata = sum_pad[WORD_W-1:0];
      SEL_SUM_HI: reg_rdata = sum_pad[SUM_W-1:WORD_W];
      default:    reg_rdata = '0;
    endcase
  end

  assign service_done = reg_wr && (sel == SEL_CTRL) && reg_wdata[SERVICE_DONE_BIT];

  assign unused_wdata_bits = ^reg_wdata[WORD_W-1:1];
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int GROUPS     = 46,
  parameter int GROUP_PINS = 4,
  parameter int WORD_W     = 32,
  localparam int NPINS     = GROUPS * GROUP_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_int_sts,
  input  logic [NPINS-1:0]  pin_wake_sts,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              parent_irq
);
  logic [GROUPS-1:0] summary_q;
  logic              service_done;
  logic              armed;

  gisum_group_reduce #(.GROUPS(GROUPS), .GROUP_PINS(GROUP_PINS)) u_reduce (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_sts  (pin_int_sts),
    .wake_sts (pin_wake_sts),
    .summary_q(summary_q)
  );

  gisum_regs #(.GROUPS(GROUPS), .WORD_W(WORD_W)) u_regs (
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .summary     (summary_q),
    .reg_rdata   (reg_rdata),
    .service_done(service_done)
  );

  gisum_arm_ctrl u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_pending (|summary_q),
    .service_done(service_done),
    .armed       (armed),
    .irq_pulse   (parent_irq)
  );
endmodule

// File: rtl/gisum_checks.sv
module gisum_checks #(
  parameter int GROUPS     = 46,
  parameter int GROUP_PINS = 4,
  parameter int WORD_W     = 32,
  localparam int NPINS     = GROUPS * GROUP_PINS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  pin_int_sts,
  input logic [NPINS-1:0]  pin_wake_sts,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              parent_irq,
  input logic [GROUPS-1:0] summary_q
);
  logic live;
  logic eoi;

  assign eoi = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  function automatic logic [GROUPS-1:0] grp_or(input logic [NPINS-1:0] a,
                                               input logic [NPINS-1:0] b);
    logic [GROUPS-1:0] r;
    r = '0;
    for (int i = 0; i < NPINS; i++) r[i / GROUP_PINS] |= a[i] | b[i];
    return r;
  endfunction

  // R2, R3: summary follows the grouped pin flags of the previous edge
  p_summary_groups_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> summary_q == $past(grp_or(pin_int_sts, pin_wake_sts)));

  // R5: single-cycle pulse unless end-of-service came with it
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && parent_irq && !$past(eoi)) |=> !parent_irq);

  // R5: no pulse without a pending summary
  p_pulse_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && parent_irq) |-> $past(summary_q != '0));

  // R7: end-of-service with pending sources fires next cycle
  p_rearm_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(eoi) && summary_q != '0) |=> parent_irq);

  // R8: control address reads zero
  p_ctrl_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> reg_rdata == '0);

  // R4: padding of the high word reads zero
  if (GROUPS > WORD_W && GROUPS < 2 * WORD_W) begin : g_pad
    p_high_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd1) |-> (reg_rdata >> (GROUPS - WORD_W)) == '0);
  end
endmodule

bind gpio_irq_summary gisum_checks #(
  .GROUPS(GROUPS), .GROUP_PINS(GROUP_PINS), .WORD_W(WORD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_int_sts (pin_int_sts),
  .pin_wake_sts(pin_wake_sts),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .parent_irq  (parent_irq),
  .summary_q   (summary_q)
);

// File: tb/sim_gpio_irq_summary.sv
`timescale 1ns/1ps
module sim_gpio_irq_summary;
  localparam int GROUPS = 46;
  localparam int GP     = 4;
  localparam int W      = 32;
  localparam int NP     = GROUPS * GP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pint = '0;
  logic [NP-1:0] pwake = '0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          irq;

  always #2.5 clk = ~clk;

  gpio_irq_summary u0 (
    .clk(clk), .rst_n(rst_n), .pin_int_sts(pint), .pin_wake_sts(pwake),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .parent_irq(irq)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";

  // reference state built from the requirements
  logic [GROUPS-1:0] m_sum = '0;
  bit                m_armed = 1'b1;
  bit                m_irq = 1'b0;
  bit                q_irq[$];
  logic [W-1:0]      q_rd[$];
  string             q_tag[$];

  function automatic logic [GROUPS-1:0] grp_or(input logic [NP-1:0] a, input logic [NP-1:0] b);
    logic [GROUPS-1:0] r;
    r = '0;
    for (int i = 0; i < NP; i++) r[i / GP] |= a[i] | b[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_read(input logic [GROUPS-1:0] s, input logic [1:0] a);
    logic [2*W-1:0] p;
    p = '0;
    p[GROUPS-1:0] = s;
    case (a)
      2'd0:    return p[W-1:0];
      2'd1:    return p[2*W-1:W];
      default: return '0;
    endcase
  endfunction

  task automatic check(input bit ok, input string t, input logic [W-1:0] act,
                       input logic [W-1:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: one expected item per clock edge
  always @(posedge clk) begin
    bit any_p;
    bit eoi;
    any_p = (m_sum != '0);
    eoi   = wr && (addr == 2'd2) && wdata[0];
    if (!rst_n) begin
      m_sum = '0; m_armed = 1'b1; m_irq = 1'b0;
    end else begin
      m_irq = m_armed && any_p;
      if (eoi) m_armed = 1'b1;
      else if (m_armed && any_p) m_armed = 1'b0;
      m_sum = grp_or(pint, pwake);
    end
    q_irq.push_back(m_irq);
    q_rd.push_back(exp_read(m_sum, addr));
    q_tag.push_back(tag);
  end

  // monitor: compares just after each edge, before inputs move
  always @(posedge clk) begin
    #1;
    if (q_irq.size() > 0) begin
      bit           ei;
      logic [W-1:0] er;
      string        et;
      ei = q_irq.pop_front();
      er = q_rd.pop_front();
      et = q_tag.pop_front();
      check(irq === ei, et, {31'd0, irq}, {31'd0, ei}, "parent_irq");
      check(rdata === er, et, rdata, er, "reg_rdata");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    tag = "R1";
    addr = 2'd0; cyc(1); addr = 2'd1; cyc(1); addr = 2'd2; cyc(1); addr = 2'd3; cyc(1);

    // R5: first pending source gives one pulse
    tag = "R5"; addr = 2'd0;
    pint[0] = 1'b1; cyc(4);

    // R6: disarmed, other sources arrive and leave
    tag = "R6";
    pint[7] = 1'b1; pwake[100] = 1'b1; addr = 2'd1; cyc(3);
    pint[7] = 1'b0; addr = 2'd0; cyc(3);

    // R7: end-of-service with sources still pending fires again
    tag = "R7";
    write_reg(2'd2, 32'h1); cyc(3);

    // R7: end-of-service with nothing pending, then a late source
    pint = '0; pwake = '0; cyc(3);
    write_reg(2'd2, 32'h1); cyc(4);
    tag = "R3";
    addr = 2'd1; pwake[NP-1] = 1'b1; cyc(4);

    // R8: control write without the service bit keeps the line quiet
    tag = "R8";
    write_reg(2'd2, 32'hFFFF_FFFE); addr = 2'd2; cyc(4);
    write_reg(2'd2, 32'hFFFF_FFFF); cyc(3);

    // R9: writes to the other addresses are ignored
    tag = "R9";
    pint[40] = 1'b1; cyc(2);
    write_reg(2'd0, 32'hFFFF_FFFF); write_reg(2'd1, 32'hFFFF_FFFF);
    write_reg(2'd3, 32'hFFFF_FFFF);
    addr = 2'd3; cyc(2); addr = 2'd0; cyc(2);

    // R2: walk one pin at a time, alternating the flag kind (R3)
    tag = "R2";
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      pint = '0; pwake = '0;
      if (p % 2 == 1) pint[p] = 1'b1; else pwake[p] = 1'b1;
      addr = ((p / GP) >= W) ? 2'd1 : 2'd0;
      @(negedge clk);
    end

    // R4: every source pending, both words and the pad bits
    tag = "R4";
    pint = '1; addr = 2'd0; cyc(2); addr = 2'd1; cyc(2);
    pint = '0; pwake = '1; cyc(2); pwake = '0; cyc(2);

    // R7: end-of-service held while sources stay pending
    tag = "R7";
    pint[12] = 1'b1; cyc(2);
    @(negedge clk); wr = 1'b1; addr = 2'd2; wdata = 32'h1;
    cyc(4);
    wr = 1'b0; wdata = '0; cyc(4);
    pint = '0; cyc(2);

    // R5: random traffic with sparse sources and service writes
    tag = "R5";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      for (int j = 0; j < 4; j++) begin
        int unsigned pin_sel;
        pin_sel = $urandom_range(NP - 1, 0);
        if ($urandom_range(1, 0) == 1) pint[pin_sel] = ~pint[pin_sel];
        else pwake[pin_sel] = ~pwake[pin_sel];
      end
      if ($urandom_range(7, 0) == 0) pint = '0;
      if ($urandom_range(7, 0) == 0) pwake = '0;
      addr  = 2'($urandom_range(3, 0));
      wr    = ($urandom_range(5, 0) == 0);
      wdata = $urandom;
    end
    @(negedge clk); wr = 1'b0; wdata = '0;
    cyc(3);
    finish_run();
  end
endmodule